// File: doc/BRIEF.md
# Serial Receiver with Character FIFO and Interrupt Logic

This block is the receive side of a register-mapped serial port. An oversampling deserializer recovers characters from the asynchronous input line, using a 16x sample tick from an external rate generator. Each character goes into a 16-deep queue together with its own status flags. Software drains the queue through a small register port. Three maskable conditions drive a single interrupt line: characters lost to a full queue, a fill level that has reached a programmed mark, and a character left unread for too long.

The frame format comes in on configuration pins. These set 5 to 8 data bits, an optional parity bit that is checked as even or odd, and one stop bit. The register port holds the enables, a self-clearing queue reset, the fill mark, the idle limit and the interrupt masks. Reads take effect in the cycle the strobe is sampled, and the data is returned on the following cycle.

Top module: `uart_rx_unit`

## Requirements
- R1: After reset the queue is empty, the control and interrupt registers read 0, and `irq` is low.
- R2: Register map, selected by `reg_addr`. Address 0 is the data word. Reading it pops one entry, and writes to it are ignored. Address 1 is control: bit 0 enables receive, bit 1 enables the tick generator, bit 2 is the queue reset, bits [7:4] hold the idle limit and bits [12:8] the fill mark. Address 2 is interrupt: bits [3:0] are read-only status (lost data, level, idle, not empty), bits [10:8] are masks for the first three, and bits [20:16] give the fill count. `cfg_bits` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. A character is taken in LSB first and returned right-aligned in data word bits [7:0], with bit 8 set.
- R3: When `cfg_par_en` is set, one parity bit follows the data. `cfg_par_even` selects even parity, and a mismatch sets bit 9 of that entry.
- R4: A stop bit sampled low sets bit 10 of the entry. If the data, the parity bit and the stop bit are all low, bit 11 (break) is also set. After such a frame the receiver waits for the line to go high again, so a long break yields a single entry.
- R5: Entries leave in arrival order. A data read from an empty queue returns 0 and changes nothing.
- R6: A character that arrives while the queue holds 16 entries, with no pop in the same cycle, is dropped and sets the lost-data status. Data reads do not clear this status.
- R7: Writing 1 to control bit 2 empties the queue and clears the lost-data and idle status. The bit always reads back 0.
- R8: The level status is set while the fill count is nonzero and at or above the fill mark.
- R9: While the queue is not empty, an idle counter advances on each tick. The idle status is set once the counter reaches the idle limit times one character time (16 ticks for each start, data, parity and stop bit). Any push or pop restarts the count and clears the status. A limit of 0 disables the idle status.
- R10: `irq` is high one cycle after any of the lost-data, level and idle status bits is set and its mask is also set.
- R11: Characters are received only while control bits 0 and 1 are both set.
- R12: A push and a pop in the same cycle both take effect, and the fill count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_bits | input | 2 | Data bit count code (0..3 gives 5..8) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The risky coincidence is a finished character landing in the queue in the same cycle that software pops the previous one. The bench preloads one character and then sends a second. It issues a single data read at a series of cycle offsets that sweep across the moment the second stop bit is sampled. In each trial it requires the popped word to be the first character, then the fill count to read 1, then the next pop to return the second character intact.

// File: rtl/urx_pkg.sv
package urx_pkg;

  // One queue entry: status flags above the data byte.
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic       valid;
    logic [7:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_IRQ  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_e;

endpackage

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] bits_code,
  input  logic       par_en,
  input  logic       par_even,
  output logic       push,
  output rx_word_t   word
);

  localparam int CNTW = $clog2(OVS);
  localparam logic [CNTW-1:0] MID_C = CNTW'(OVS / 2 - 1);
  localparam logic [CNTW-1:0] END_C = CNTW'(OVS - 1);

  logic [1:0]      sync_q;
  logic            line;
  rx_state_e       st;
  logic [CNTW-1:0] cnt;
  logic [2:0]      idx;
  logic [7:0]      sh;
  logic            ones;
  logic            pbit;
  logic [2:0]      last_idx;
  logic            perr_c;
  logic            brk_c;

  assign line     = sync_q[1];
  assign last_idx = 3'd4 + {1'b0, bits_code};
  assign perr_c   = par_en & (ones ^ pbit ^ ~par_even);
  assign brk_c    = (sh == 8'd0) & ~pbit & ~line;

  // two-flop synchronizer, idles high
  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st   <= S_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      ones <= 1'b0;
      pbit <= 1'b0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            if (!line) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == MID_C) begin
              cnt <= '0;
              if (line) begin
                st <= S_IDLE;
              end else begin
                st   <= S_DATA;
                idx  <= '0;
                sh   <= '0;
                ones <= 1'b0;
                pbit <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == END_C) begin
              cnt     <= '0;
              sh[idx] <= line;
              ones    <= ones ^ line;
              if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
              else                 idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == END_C) begin
              cnt  <= '0;
              pbit <= line;
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == END_C) begin
              cnt        <= '0;
              push       <= 1'b1;
              word.data  <= sh;
              word.valid <= 1'b1;
              word.perr  <= perr_c;
              word.ferr  <= ~line;
              word.brk   <= brk_c;
              st         <= line ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HOLD: begin
            if (line) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop_req,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       push_ok,
  output logic                       pop_ok,
  output logic                       ovf
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LV = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;

  assign pop_ok  = pop_req && (fill != '0);
  assign push_ok = push && ((fill != FULL_LV) || pop_ok);
  assign ovf     = push && !push_ok;

  // storage without reset so it can map to block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/urx_irq.sv
module urx_irq #(
  parameter int CW    = 5,
  parameter int TMO_W = 4,
  parameter int CTW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             active,
  input  logic             tick,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic             ovf,
  input  logic [CW-1:0]    fill,
  input  logic [CW-1:0]    thr,
  input  logic [TMO_W-1:0] tmo_chars,
  input  logic [CTW-1:0]   char_ticks,
  input  logic [2:0]       mask,
  output logic [3:0]       stat,
  output logic             irq
);

  localparam int TCW = TMO_W + CTW;

  logic           ovr_q;
  logic           tmo_q;
  logic           lvl;
  logic [TCW-1:0] tcnt;
  logic [TCW-1:0] limit;

  assign limit = TCW'(tmo_chars) * TCW'(char_ticks);
  assign lvl   = (fill != '0) && (fill >= thr);
  assign stat  = {fill != '0, tmo_q, lvl, ovr_q};

  always_ff @(posedge clk) begin
    if (rst || clr)  ovr_q <= 1'b0;
    else if (ovf)    ovr_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || push_ok || pop_ok || fill == '0) begin
      tcnt  <= '0;
      tmo_q <= 1'b0;
    end else if (active && tick && tmo_chars != '0 && !tmo_q) begin
      tcnt <= tcnt + 1'b1;
      if (tcnt == limit - TCW'(1)) tmo_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat[2:0] & mask);
  end

endmodule

// File: rtl/uart_rx_unit.sv
module uart_rx_unit
  import urx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int TMO_W = 4,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  input  logic             os_tick,
  input  logic [1:0]       cfg_bits,
  input  logic             cfg_par_en,
  input  logic             cfg_par_even,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);

  localparam int CW      = $clog2(DEPTH + 1);
  localparam int CTW     = $clog2(OVS * 12 + 1);
  localparam int TMO_LSB = 4;
  localparam int THR_LSB = TMO_LSB + TMO_W;
  localparam int MSK_LSB = 8;
  localparam int FIL_LSB = 16;

  logic             rx_en_q, gen_en_q, clr_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CW-1:0]    thr_q;
  logic [2:0]       mask_q;
  logic             active;
  logic             deser_push;
  rx_word_t         deser_word;
  logic [WORD_W-1:0] fifo_rd;
  logic [CW-1:0]    fifo_fill;
  logic             push_ok, pop_ok, ovf;
  logic [3:0]       stat;
  logic [3:0]       frame_bits;
  logic [CTW-1:0]   char_ticks;
  logic [REG_W-1:0] ctrl_word, irq_word, csr_rd_q;
  logic             from_fifo_q;
  logic             wdata_unused;

  assign active       = rx_en_q & gen_en_q;
  assign frame_bits   = 4'd7 + {2'b0, cfg_bits} + {3'b0, cfg_par_en};
  assign char_ticks   = CTW'(frame_bits) * CTW'(OVS);
  assign wdata_unused = ^reg_wdata;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = rx_en_q;
    ctrl_word[1] = gen_en_q;
    ctrl_word[TMO_LSB +: TMO_W] = tmo_q;
    ctrl_word[THR_LSB +: CW]    = thr_q;
    irq_word = '0;
    irq_word[3:0]            = stat;
    irq_word[MSK_LSB +: 3]   = mask_q;
    irq_word[FIL_LSB +: CW]  = fifo_fill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en_q  <= 1'b0;
      gen_en_q <= 1'b0;
      clr_q    <= 1'b0;
      tmo_q    <= '0;
      thr_q    <= '0;
      mask_q   <= '0;
    end else begin
      clr_q <= 1'b0;
      if (reg_wr && reg_addr == A_CTRL) begin
        rx_en_q  <= reg_wdata[0];
        gen_en_q <= reg_wdata[1];
        clr_q    <= reg_wdata[2];
        tmo_q    <= reg_wdata[TMO_LSB +: TMO_W];
        thr_q    <= reg_wdata[THR_LSB +: CW];
      end
      if (reg_wr && reg_addr == A_IRQ) mask_q <= reg_wdata[MSK_LSB +: 3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rd_q    <= '0;
      from_fifo_q <= 1'b0;
    end else if (reg_rd) begin
      from_fifo_q <= pop_ok;
      case (reg_addr)
        A_CTRL:  csr_rd_q <= ctrl_word;
        A_IRQ:   csr_rd_q <= irq_word;
        default: csr_rd_q <= '0;
      endcase
    end
  end

  assign reg_rdata = from_fifo_q ? REG_W'(fifo_rd) : csr_rd_q;

  urx_deser #(.OVS(OVS)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .tick      (os_tick),
    .rxd       (rx_line),
    .bits_code (cfg_bits),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .push      (deser_push),
    .word      (deser_word)
  );

  urx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_q),
    .push    (deser_push),
    .wdata   (deser_word),
    .pop_req (reg_rd && reg_addr == A_DATA),
    .rdata   (fifo_rd),
    .fill    (fifo_fill),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .ovf     (ovf)
  );

  urx_irq #(.CW(CW), .TMO_W(TMO_W), .CTW(CTW)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr_q),
    .active     (active),
    .tick       (os_tick),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .ovf        (ovf),
    .fill       (fifo_fill),
    .thr        (thr_q),
    .tmo_chars  (tmo_q),
    .char_ticks (char_ticks),
    .mask       (mask_q),
    .stat       (stat),
    .irq        (irq)
  );

endmodule

// File: rtl/uart_rx_unit_chk.sv
module uart_rx_unit_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic [CW-1:0] fill,
  input logic [3:0]    stat,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          active,
  input logic          deser_push
);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(fill) <= DEPTH);

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat[0] && !clr |=> stat[0]);

  // R7
  queue_reset_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill == '0) && !stat[0] && !stat[2]);

  // R9
  idle_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    stat[2] |-> fill != '0);

  // R11
  gated_receive_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> !deser_push);

  // R12
  push_pop_same_chk: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok && !clr |=> $stable(fill));

  // R5
  push_grows_chk: assert property (@(posedge clk) disable iff (rst)
    push_ok && !pop_ok && !clr |=> 32'(fill) == 32'($past(fill)) + 1);

endmodule

bind uart_rx_unit uart_rx_unit_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr_q),
  .fill       (fifo_fill),
  .stat       (stat),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .active     (active),
  .deser_push (deser_push)
);

// File: tb/uart_rx_unit_test.sv
module uart_rx_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic        os_tick = 1'b1;
  logic [1:0]  cfg_bits = 2'd3;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_even = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_rx_unit uut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .os_tick(os_tick),
    .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl(input int tmo, input int thr, input bit clr);
    return 32'(thr << 8) | 32'(tmo << 4) | (clr ? 32'h4 : 32'h0) | 32'h3;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame with the current cfg; flip_par corrupts parity, stopv is the stop level
  task automatic send(input logic [7:0] d, input bit flip_par, input bit stopv, input int hold_low);
    int nb;
    logic [7:0] dm;
    logic p;
    nb = 5 + int'(cfg_bits);
    dm = d & 8'((1 << nb) - 1);
    p = (^dm) ^ ~cfg_par_even ^ flip_par;
    @(negedge clk);
    rx_line = 1'b0; idle(16);
    for (int i = 0; i < nb; i++) begin
      rx_line = dm[i]; idle(16);
    end
    if (cfg_par_en) begin
      rx_line = p; idle(16);
    end
    rx_line = stopv; idle(16);
    if (!stopv) idle(hold_low);
    rx_line = 1'b1; idle(16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] val;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(2'd1, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd2, v); chk("R1 irq reg", v, 32'h0);
    chk("R1 irq pin", {31'd0, irq}, 32'h0);
    rd(2'd0, v); chk("R1 R5 empty read", v, 32'h0);

    // R11 gating: only one enable set
    wr(2'd1, 32'h1000 | 32'h1);
    send(8'h5A, 0, 1, 0);
    rd(2'd2, v); chk("R11 rx only", v, 32'h0);
    wr(2'd1, 32'h1000 | 32'h2);
    send(8'h5A, 0, 1, 0);
    rd(2'd2, v); chk("R11 gen only", v, 32'h0);

    // R7 readback: queue reset bit reads 0, fields kept
    wr(2'd1, ctrl(3, 16, 1));
    rd(2'd1, v); chk("R7 R2 ctrl readback", v, ctrl(3, 16, 0));
    wr(2'd1, ctrl(0, 16, 0));
    wr(2'd0, 32'hFFF);
    rd(2'd2, v); chk("R2 data write ignored", v, 32'h0);

    // R2 R3 format sweep
    for (int c = 0; c < 4; c++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int k = 0; k < 3; k++) begin
          cfg_bits = 2'(c);
          cfg_par_en = (pm != 0);
          cfg_par_even = (pm == 1);
          val = 8'(k * 83 + c * 29 + pm * 7 + 1) & 8'((1 << (5 + c)) - 1);
          send(val, 0, 1, 0);
          rd(2'd0, v); chk("R2 R3 format", v, 32'h100 | 32'(val));
        end
      end
    end

    // R3 parity errors, both senses
    cfg_bits = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
    send(8'h6B, 1, 1, 0);
    rd(2'd0, v); chk("R3 even mismatch", v, 32'h36B);
    cfg_par_even = 1'b0;
    send(8'h6B, 1, 1, 0);
    rd(2'd0, v); chk("R3 odd mismatch", v, 32'h36B);

    // R4 framing and break
    cfg_par_en = 1'b0;
    send(8'h55, 0, 0, 0);
    rd(2'd0, v); chk("R4 framing", v, 32'h555);
    send(8'h00, 0, 0, 64);
    rd(2'd2, v); chk("R4 long break one entry", v, 32'h10008);
    rd(2'd0, v); chk("R4 break flags", v, 32'hD00);
    cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    send(8'h00, 1, 0, 0);
    rd(2'd0, v); chk("R4 break odd parity", v, 32'hF00);
    cfg_par_en = 1'b0;

    // R6 overrun with 17 characters, R5 order
    for (int i = 0; i < 17; i++) send(8'(8'h20 + i), 0, 1, 0);
    rd(2'd2, v); chk("R6 R8 full", v, 32'h10000B);
    for (int i = 0; i < 16; i++) begin
      rd(2'd0, v); chk("R5 order", v, 32'h100 | 32'(8'h20 + i));
    end
    rd(2'd0, v); chk("R5 empty read", v, 32'h0);
    rd(2'd2, v); chk("R6 sticky after reads", v, 32'h1);
    wr(2'd1, ctrl(0, 16, 1));
    rd(2'd2, v); chk("R7 clears overrun", v, 32'h0);

    // R8 R10 level interrupt
    wr(2'd1, ctrl(0, 4, 0));
    wr(2'd2, 32'h200);
    for (int i = 0; i < 3; i++) send(8'(8'h40 + i), 0, 1, 0);
    rd(2'd2, v); chk("R8 below mark", v, 32'h30208);
    idle(2); chk("R10 pin low", {31'd0, irq}, 32'h0);
    send(8'h43, 0, 1, 0);
    rd(2'd2, v); chk("R8 at mark", v, 32'h4020A);
    idle(2); chk("R10 pin high", {31'd0, irq}, 32'h1);
    rd(2'd0, v); chk("R5 pop under level", v, 32'h140);
    idle(2); chk("R10 pin drops", {31'd0, irq}, 32'h0);
    wr(2'd2, 32'h0);
    send(8'h44, 0, 1, 0);
    idle(2); chk("R10 masked", {31'd0, irq}, 32'h0);
    rd(2'd2, v); chk("R8 unmasked status", v, 32'h4000A);
    wr(2'd1, ctrl(0, 4, 1));
    rd(2'd2, v); chk("R7 clears level", v, 32'h0);

    // R9 idle timeout, one 8N1 character time
    wr(2'd1, ctrl(1, 16, 0));
    wr(2'd2, 32'h400);
    send(8'h77, 0, 1, 0);
    idle(100);
    rd(2'd2, v); chk("R9 before limit", v, 32'h10408);
    idle(80);
    rd(2'd2, v); chk("R9 after limit", v, 32'h1040C);
    idle(2); chk("R10 idle pin", {31'd0, irq}, 32'h1);
    rd(2'd0, v); chk("R9 pop data", v, 32'h177);
    rd(2'd2, v); chk("R9 pop clears", v, 32'h400);
    idle(2); chk("R10 idle pin drops", {31'd0, irq}, 32'h0);

    // R9 two 7N1 character times
    cfg_bits = 2'd2;
    wr(2'd1, ctrl(2, 16, 0));
    send(8'h2A, 0, 1, 0);
    idle(230);
    rd(2'd2, v); chk("R9 7N1 before", v, 32'h10408);
    idle(80);
    rd(2'd2, v); chk("R9 7N1 after", v, 32'h1040C);
    wr(2'd1, ctrl(2, 16, 1));
    rd(2'd2, v); chk("R7 clears idle", v, 32'h400);
    wr(2'd2, 32'h0);
    cfg_bits = 2'd3;

    // R12 pop swept across the push of a second character
    wr(2'd1, ctrl(0, 16, 0));
    for (int k = 0; k < 14; k++) begin
      wr(2'd1, ctrl(0, 16, 1));
      send(8'hA5, 0, 1, 0);
      fork
        send(8'h3C, 0, 1, 0);
        begin
          idle(146 + k);
          rd(2'd0, v); chk("R12 first out", v, 32'h1A5);
        end
      join
      rd(2'd2, v); chk("R12 fill one", v, 32'h10008);
      rd(2'd0, v); chk("R12 second out", v, 32'h13C);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule